// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches a set of external interrupt pins plus one non-maskable interrupt pin and turns qualifying pin activity into sticky request flags. Each external line has its own two-bit sense field that picks low-level, falling-edge, rising-edge or both-edge detection. The flags drive one request output per line toward a downstream interrupt controller, which handles masking, priority and vectoring.

Software reaches the block over a small 16-bit register bus with a byte offset, a write strobe, a read strobe, write data and combinational read data. A request flag is cleared by writing 0 to its bit, and writing 1 leaves it alone. Software can therefore clear one line without disturbing the others by writing all ones except that bit. The non-maskable pin has a selectable edge and its own flag. That flag can only be cleared once it has been read back as set.

All pins pass through a two-flop synchroniser. Edges are found by comparing the synchronised value with its value one cycle earlier. The synchroniser resets to the high (idle) level, so releasing reset with the pins idle produces no spurious events.

Top module: `exti_sense_ctrl`

## Requirements
- R1: After reset all line request flags and the NMI flag are 0, every sense field is 0 (low-level), and the NMI edge select is 0 (falling). Offset 2 reads 0x0000, offset 4 reads 0x0000, and with the NMI pin high offset 0 reads 0x8000.
- R2: A pin change reaches its request flag on the third rising clock edge after the pin settles: two synchroniser stages plus one edge-compare stage.
- R3: Sense code 0 (low level) sets a line's flag on every cycle its synchronised input is low, so a software clear while the pin is still low has no lasting effect.
- R4: Sense code 1 sets a line's flag when its synchronised input goes from high to low.
- R5: Sense code 2 sets a line's flag when its synchronised input goes from low to high, and a high-to-low change does nothing.
- R6: Sense code 3 sets a line's flag on any change of its synchronised input.
- R7: The register at offset 2 holds the sense code of line n in bits [2n+1:2n]. It is read/write and reads back the last value written.
- R8: The register at offset 4 shows the flag of line n in bit n, with bits 15:8 reading 0. A write clears each flag whose data bit is 0 and keeps each flag whose data bit is 1.
- R9: If a detected event and a software clear hit the same flag in the same cycle, the flag ends up set.
- R10: At offset 0, bit 15 reads the synchronised NMI pin level. Bit 8 is a read/write NMI edge select (0 falling, 1 rising). Bit 1 is the NMI flag, set by the selected edge. All other bits read 0.
- R11: Writing 0 to bit 1 at offset 0 clears the NMI flag only if a read strobe at offset 0 has already seen the flag as 1. Without that read, the write leaves the flag set.
- R12: `line_req[n]` always equals line n's request flag and `nmi_req` equals the NMI flag. Offsets other than 0, 2 and 4 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pins | input | NUM_LINES | Asynchronous external interrupt pins |
| nmi_pin | input | 1 | Asynchronous non-maskable interrupt pin |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (arms the NMI flag clear) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| line_req | output | NUM_LINES | Per-line request outputs |
| nmi_req | output | 1 | NMI request output |

## Verification
The bench builds the block with its defaults: eight lines, a 16-bit bus and a 3-bit offset. With these values every sense code fits in a single control word, and a mixed configuration in which each code is used by two lines can be driven at once. A sample-history model in the bench predicts both request outputs and the read data on every cycle. Directed phases pin down the three-edge latency, a clear landing in the same cycle as an event, and the NMI read-before-clear rule. A random phase then mixes pin toggles with writes, reads and unmapped offsets.

// File: rtl/exti_pkg.sv
package exti_pkg;

    localparam int REG_W        = 16;
    localparam int OFS_NMI_CTRL = 0;
    localparam int OFS_SENSE    = 2;
    localparam int OFS_REQ      = 4;
    localparam int NMI_LVL_BIT  = 15;
    localparam int NMI_EDGE_BIT = 8;
    localparam int NMI_FLAG_BIT = 1;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'd0,
        SENSE_FALL = 2'd1,
        SENSE_RISE = 2'd2,
        SENSE_BOTH = 2'd3
    } sense_e;

    typedef struct packed {
        logic wr_nmi;
        logic wr_sense;
        logic wr_req;
        logic rd_nmi;
    } bus_dec_t;

    function automatic logic sense_event(sense_e mode, logic cur, logic prev);
        logic hit;
        case (mode)
            SENSE_LOW:  hit = ~cur;
            SENSE_FALL: hit = prev & ~cur;
            SENSE_RISE: hit = ~prev & cur;
            default:    hit = prev ^ cur;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/exti_sync.sv
module exti_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '1;
            stage2_q <= '1;
            prev_q   <= '1;
        end else begin
            stage1_q <= din;
            stage2_q <= stage1_q;
            prev_q   <= stage2_q;
        end
    end

    assign cur  = stage2_q;
    assign prev = prev_q;
endmodule

// File: rtl/exti_detect.sv
module exti_detect
    import exti_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [2*N-1:0] sense,
    input  logic [N-1:0]   cur,
    input  logic [N-1:0]   prev,
    output logic [N-1:0]   hit
);
    for (genvar g = 0; g < N; g++) begin : g_line
        assign hit[g] = sense_event(sense_e'(sense[2*g +: 2]), cur[g], prev[g]);
    end
endmodule

// File: rtl/exti_sense_ctrl.sv
module exti_sense_ctrl
    import exti_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int DATA_W    = REG_W,
    parameter int ADDR_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_pins,
    input  logic                 nmi_pin,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic                 bus_re,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_LINES-1:0] line_req,
    output logic                 nmi_req
);
    localparam int SYNC_W  = NUM_LINES + 1;
    localparam int SENSE_W = 2 * NUM_LINES;
    localparam int NMI_IDX = NUM_LINES;

    logic [SYNC_W-1:0]    cur_s, prev_s;
    logic [SENSE_W-1:0]   sense_q;
    logic [NUM_LINES-1:0] hit, flag_q, flag_nxt;
    logic                 nmi_edge_q, nmi_flag_q, nmi_seen_q;
    logic                 nmi_hit, nmi_flag_nxt, nmi_seen_nxt;
    bus_dec_t             dec;

    exti_sync #(.W(SYNC_W)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({nmi_pin, irq_pins}),
        .cur  (cur_s),
        .prev (prev_s)
    );

    exti_detect #(.N(NUM_LINES)) u_detect (
        .sense (sense_q),
        .cur   (cur_s[NUM_LINES-1:0]),
        .prev  (prev_s[NUM_LINES-1:0]),
        .hit   (hit)
    );

    always_comb begin
        dec.wr_nmi   = bus_we && (int'(bus_addr) == OFS_NMI_CTRL);
        dec.wr_sense = bus_we && (int'(bus_addr) == OFS_SENSE);
        dec.wr_req   = bus_we && (int'(bus_addr) == OFS_REQ);
        dec.rd_nmi   = bus_re && (int'(bus_addr) == OFS_NMI_CTRL);
    end

    // NMI edge: rising when the select bit is 1, falling otherwise
    assign nmi_hit = nmi_edge_q ? (cur_s[NMI_IDX] & ~prev_s[NMI_IDX])
                                : (~cur_s[NMI_IDX] & prev_s[NMI_IDX]);

    always_comb begin
        flag_nxt = flag_q;
        if (dec.wr_req) flag_nxt = flag_q & bus_wdata[NUM_LINES-1:0];
        flag_nxt = flag_nxt | hit;

        nmi_flag_nxt = nmi_flag_q;
        if (dec.wr_nmi && !bus_wdata[NMI_FLAG_BIT] && nmi_seen_q) nmi_flag_nxt = 1'b0;
        if (nmi_hit) nmi_flag_nxt = 1'b1;

        if (!nmi_flag_nxt)                nmi_seen_nxt = 1'b0;
        else if (dec.rd_nmi && nmi_flag_q) nmi_seen_nxt = 1'b1;
        else                               nmi_seen_nxt = nmi_seen_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sense_q    <= '0;
            flag_q     <= '0;
            nmi_edge_q <= 1'b0;
            nmi_flag_q <= 1'b0;
            nmi_seen_q <= 1'b0;
        end else begin
            if (dec.wr_sense) sense_q <= bus_wdata[SENSE_W-1:0];
            if (dec.wr_nmi)   nmi_edge_q <= bus_wdata[NMI_EDGE_BIT];
            flag_q     <= flag_nxt;
            nmi_flag_q <= nmi_flag_nxt;
            nmi_seen_q <= nmi_seen_nxt;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (int'(bus_addr))
            OFS_NMI_CTRL: begin
                bus_rdata[NMI_LVL_BIT]  = cur_s[NMI_IDX];
                bus_rdata[NMI_EDGE_BIT] = nmi_edge_q;
                bus_rdata[NMI_FLAG_BIT] = nmi_flag_q;
            end
            OFS_SENSE: bus_rdata[SENSE_W-1:0]   = sense_q;
            OFS_REQ:   bus_rdata[NUM_LINES-1:0] = flag_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign line_req = flag_q;
    assign nmi_req  = nmi_flag_q;
endmodule

// File: rtl/exti_sense_chk.sv
module exti_sense_chk #(
    parameter int NUM_LINES = 8,
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_LINES-1:0] irq_pins,
    input logic                 nmi_pin,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_we,
    input logic                 bus_re,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic [NUM_LINES-1:0] line_req,
    input logic                 nmi_req
);
    logic [1:0] since_rst;
    logic       seen_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= 2'd0;
            seen_rst  <= 1'b1;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    logic wr_req, wr_nmi_clr, wr_sense;
    assign wr_req     = bus_we && (int'(bus_addr) == 4);
    assign wr_sense   = bus_we && (int'(bus_addr) == 2);
    assign wr_nmi_clr = bus_we && (int'(bus_addr) == 0) && !bus_wdata[1];

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (line_req == '0) && !nmi_req);

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        !wr_req |=> ((line_req & $past(line_req)) == $past(line_req)));

    p_keep_on_one_r8: assert property (@(posedge clk) disable iff (rst)
        wr_req |=> (($past(line_req & bus_wdata[NUM_LINES-1:0]) & ~line_req) == '0));

    p_sense_readback_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_sense && !$past(rst)) |=> ((int'(bus_addr) != 2) ||
            (bus_rdata[2*NUM_LINES-1:0] == $past(bus_wdata[2*NUM_LINES-1:0]))));

    p_nmi_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (nmi_req && !wr_nmi_clr) |=> nmi_req);

    p_nmi_level_r10: assert property (@(posedge clk) disable iff (rst)
        (seen_rst && since_rst >= 2'd2 && int'(bus_addr) == 0) |->
            (bus_rdata[15] == $past(nmi_pin, 2)));

    p_req_view_r12: assert property (@(posedge clk) disable iff (rst)
        (int'(bus_addr) == 4) |-> (bus_rdata == DATA_W'(line_req)));
endmodule

bind exti_sense_ctrl exti_sense_chk #(
    .NUM_LINES (NUM_LINES),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_pins  (irq_pins),
    .nmi_pin   (nmi_pin),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .line_req  (line_req),
    .nmi_req   (nmi_req)
);

// File: tb/exti_sense_ctrl_tb.sv
`timescale 1ns/1ps
module exti_sense_ctrl_tb;
    localparam int NL = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [NL-1:0] irq_pins;
    logic          nmi_pin;
    logic [2:0]    bus_addr;
    logic          bus_we, bus_re;
    logic [15:0]   bus_wdata;
    logic [15:0]   bus_rdata;
    logic [NL-1:0] line_req;
    logic          nmi_req;

    int vectors = 0;
    int errors  = 0;

    always #2.5 clk = ~clk;

    exti_sense_ctrl u_dut (
        .clk(clk), .rst(rst), .irq_pins(irq_pins), .nmi_pin(nmi_pin),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .line_req(line_req), .nmi_req(nmi_req)
    );

    // Reference model: sample history h0 (latest), h1 (synced), h2 (one older)
    logic [NL:0]   h0, h1, h2;
    logic [NL-1:0] m_flag;
    logic [15:0]   m_sense;
    logic          m_edge, m_nflag, m_seen;

    always @(posedge clk) begin
        if (rst) begin
            h0 = '1; h1 = '1; h2 = '1;
            m_flag = '0; m_sense = '0; m_edge = 1'b0; m_nflag = 1'b0; m_seen = 1'b0;
        end else begin
            logic [NL-1:0] ev, nf;
            logic nev, nn, ns;
            for (int i = 0; i < NL; i++) begin
                case (m_sense[2*i +: 2])
                    2'd0:    ev[i] = !h1[i];
                    2'd1:    ev[i] = h2[i] && !h1[i];
                    2'd2:    ev[i] = !h2[i] && h1[i];
                    default: ev[i] = h2[i] != h1[i];
                endcase
            end
            nf = m_flag;
            if (bus_we && bus_addr == 3'd4) nf = nf & bus_wdata[NL-1:0];
            nf = nf | ev;
            nev = m_edge ? (h1[NL] && !h2[NL]) : (!h1[NL] && h2[NL]);
            nn = m_nflag;
            if (bus_we && bus_addr == 3'd0 && !bus_wdata[1] && m_seen) nn = 1'b0;
            if (nev) nn = 1'b1;
            ns = m_seen;
            if (bus_re && bus_addr == 3'd0 && m_nflag) ns = 1'b1;
            if (!nn) ns = 1'b0;
            if (bus_we && bus_addr == 3'd2) m_sense = bus_wdata;
            if (bus_we && bus_addr == 3'd0) m_edge = bus_wdata[8];
            m_flag = nf; m_nflag = nn; m_seen = ns;
            h2 = h1; h1 = h0; h0 = {nmi_pin, irq_pins};
        end
    end

    function automatic logic [15:0] exp_rd(logic [2:0] a);
        case (a)
            3'd0:    return {h1[NL], 6'd0, m_edge, 6'd0, m_nflag, 1'b0};
            3'd2:    return m_sense;
            3'd4:    return {8'd0, m_flag};
            default: return 16'd0;
        endcase
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        check("R12 line_req", 16'(line_req), 16'(m_flag));
        check("R12 nmi_req", 16'(nmi_req), 16'(m_nflag));
        case (bus_addr)
            3'd0:    check("R10 offset 0 read", bus_rdata, exp_rd(bus_addr));
            3'd2:    check("R7 offset 2 read", bus_rdata, exp_rd(bus_addr));
            3'd4:    check("R8 offset 4 read", bus_rdata, exp_rd(bus_addr));
            default: check("R12 unmapped read", bus_rdata, exp_rd(bus_addr));
        endcase
    endtask

    task automatic peek(logic [2:0] a, string req, logic [15:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        step();
        bus_we = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        rst = 1'b1; irq_pins = '1; nmi_pin = 1'b1;
        bus_addr = '0; bus_we = 1'b0; bus_re = 1'b0; bus_wdata = '0;
        repeat (3) step();
        rst = 1'b0;
        step();
        peek(3'd2, "R1 sense reset", 16'h0000);
        peek(3'd4, "R1 flags reset", 16'h0000);
        peek(3'd0, "R1 nmi ctrl reset", 16'h8000);

        // R2 / R3: low-level latency and clear while low
        bus_addr = 3'd4;
        irq_pins[0] = 1'b0;
        step(); step();
        check("R2 no flag after two edges", 16'(line_req[0]), 16'd0);
        step();
        check("R2 flag on third edge", 16'(line_req[0]), 16'd1);
        wr(3'd4, 16'hFFFE);
        check("R3 clear while low ineffective", 16'(line_req[0]), 16'd1);
        irq_pins[0] = 1'b1;
        repeat (3) step();
        wr(3'd4, 16'hFFFE);
        check("R8 write 0 clears", 16'(line_req), 16'h0000);

        // R7: mixed sense configuration
        wr(3'd2, 16'h3939);
        peek(3'd2, "R7 sense readback", 16'h3939);

        // R4: falling on line 0
        irq_pins[0] = 1'b0;
        repeat (3) step();
        check("R4 falling sets", 16'(line_req[0]), 16'd1);
        wr(3'd4, 16'hFFFE);
        check("R8 single-bit clear", 16'(line_req), 16'h0000);

        // R5: rising on line 1
        irq_pins[1] = 1'b0;
        repeat (4) step();
        check("R5 falling ignored", 16'(line_req[1]), 16'd0);
        irq_pins[1] = 1'b1;
        repeat (3) step();
        check("R5 rising sets", 16'(line_req[1]), 16'd1);
        wr(3'd4, 16'h0000);
        check("R8 clear all", 16'(line_req), 16'h0000);

        // R6: both edges on line 2
        irq_pins[2] = 1'b0;
        repeat (3) step();
        check("R6 falling sets", 16'(line_req[2]), 16'd1);
        wr(3'd4, 16'h0000);
        irq_pins[2] = 1'b1;
        repeat (3) step();
        check("R6 rising sets", 16'(line_req[2]), 16'd1);
        wr(3'd4, 16'h0000);

        // R9: event and clear on the same edge
        irq_pins[1] = 1'b0;
        repeat (3) step();
        irq_pins[1] = 1'b1;
        step(); step();
        wr(3'd4, 16'h0000);
        check("R9 event beats clear", 16'(line_req[1]), 16'd1);
        wr(3'd4, 16'h0000);

        // R10 / R11: NMI
        nmi_pin = 1'b0;
        repeat (3) step();
        check("R10 nmi falling sets", 16'(nmi_req), 16'd1);
        peek(3'd0, "R10 nmi ctrl view", 16'h0002);
        wr(3'd0, 16'h0000);
        check("R11 clear without read ignored", 16'(nmi_req), 16'd1);
        bus_addr = 3'd0; bus_re = 1'b1;
        step();
        bus_re = 1'b0;
        wr(3'd0, 16'h0000);
        check("R11 clear after read", 16'(nmi_req), 16'd0);
        wr(3'd0, 16'h0102);
        nmi_pin = 1'b1;
        repeat (3) step();
        check("R10 nmi rising sets", 16'(nmi_req), 16'd1);
        peek(3'd0, "R10 nmi ctrl rising view", 16'h8102);

        // Random mix
        for (int n = 0; n < 600; n++) begin
            irq_pins  = ($urandom_range(0, 3) == 0) ? NL'($urandom) : irq_pins;
            nmi_pin   = ($urandom_range(0, 7) == 0) ? ~nmi_pin : nmi_pin;
            bus_addr  = 3'($urandom);
            bus_we    = ($urandom_range(0, 3) == 0);
            bus_re    = !bus_we && ($urandom_range(0, 1) == 0);
            bus_wdata = 16'($urandom);
            step();
        end
        bus_we = 1'b0; bus_re = 1'b0;
        step();
        summary();
    end
endmodule